// File: doc/BRIEF.md
# Fine Phase Step Sequencer

This block drives the variable fine phase-adjust port of a clock-management tile. That port has three signals, all timed by the phase-adjust clock:
- a request strobe,
- a direction select,
- a completion pulse that comes back from the tile.

The sequencer turns user commands into correctly formed requests. A command is either a single step up or down, or a continuous sweep that walks the phase back and forth between two bounds.

The sequencer keeps the current phase offset in its own signed counter. That counter is the only thing that decides when a sweep turns around. The tile's own overflow indication is not used, because it can toggle near the range ends. The block also reports:
- when the offset sits on a bound,
- a rejected out-of-range step,
- a missing completion pulse (timeout).

Top module: `phase_step_seq`

## Requirements
- R1: A synchronous reset sets the offset to 0 and returns the sequencer to idle. During reset and in the cycle after it, `ps_en`, `busy`, `range_err` and `tmo_err` are low.
- R2: The direction select `ps_incdec` is written one cycle before `ps_en` and held until the step ends. `ps_en` is high for exactly one cycle per request.
- R3: No new request is issued while a step is outstanding. A `ps_done` pulse outside the wait for completion has no effect on the offset.
- R4: The offset changes only on the clock edge that samples `ps_done` during the wait. It moves by +1 when `ps_incdec`=1 and by -1 when `ps_incdec`=0, and is visible from the next cycle.
- R5: The bounds depend on `centered`. With `centered`=1 they are [-LIMIT, +LIMIT]; with `centered`=0 they are [0, +LIMIT]. A single-step command whose target lies outside these bounds issues no request, leaves the offset unchanged, and raises `range_err` for one cycle, one cycle after the command.
- R6: While `sweep_on`=1 the sequencer issues steps back to back. A sweep starts upward, and a step taken from the upper bound goes down. A step taken from the lower bound goes up; otherwise the previous direction is kept.
- R7: If `ps_done` has not arrived by the end of the TIMEOUT-th cycle of the wait, `tmo_err` pulses for one cycle. The sequencer is idle in that same cycle and the offset is unchanged.
- R8: `at_bound` is high exactly when the offset equals the current lower or upper bound.
- R9: `step_req` is ignored while a step is in progress or while `sweep_on`=1.
- R10: A reset in the middle of a step abandons the step and clears the offset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-adjust clock |
| rst | input | 1 | Synchronous reset, active high |
| step_req | input | 1 | Single-step command strobe |
| step_up | input | 1 | Direction of the single step (1 = up) |
| sweep_on | input | 1 | Continuous sweep enable |
| centered | input | 1 | 1 = symmetric bounds, 0 = non-negative bounds |
| ps_done | input | 1 | Completion pulse from the tile |
| ps_en | output | 1 | One-cycle request strobe to the tile |
| ps_incdec | output | 1 | Direction select to the tile (1 = increment) |
| busy | output | 1 | A step is in progress |
| pos | output | POS_W | Signed current phase offset |
| at_bound | output | 1 | Offset equals a bound |
| range_err | output | 1 | Single step rejected (one-cycle pulse) |
| tmo_err | output | 1 | Completion timeout (one-cycle pulse) |

## Verification
The hardest states to reach from the ports are the sweep turnarounds. A turnaround happens only after hundreds of completed steps, each with its own round trip through the responder. The bench reaches them by leaving the sweep running under a responder with varying delays until the offset has hit the top bound and come back to zero. It then lets a symmetric sweep run long enough to cross zero.

Two further situations need a late or missing completion pulse:
- A muted responder produces the timeout.
- A reset issued while a long-delayed step is pending leaves a stray completion pulse arriving at an idle sequencer.

// File: rtl/phase_step_seq.sv
module phase_step_seq #(
  parameter int POS_W   = 10,
  parameter int LIMIT   = 255,
  parameter int TIMEOUT = 256
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step_req,
  input  logic                    step_up,
  input  logic                    sweep_on,
  input  logic                    centered,
  input  logic                    ps_done,
  output logic                    ps_en,
  output logic                    ps_incdec,
  output logic                    busy,
  output logic signed [POS_W-1:0] pos,
  output logic                    at_bound,
  output logic                    range_err,
  output logic                    tmo_err
);
  localparam int WD_W = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_PULSE, S_WAIT} st_t;
  st_t st;

  logic [WD_W-1:0]        wd;
  logic                   dir_q;
  logic signed [POS_W-1:0] lo, hi;
  logic signed [POS_W:0]   pos_x, lo_x, hi_x, tgt;
  logic in_rng, sw_up, idle_cmd;

  assign hi    = POS_W'(LIMIT);
  assign lo    = centered ? -hi : '0;
  assign pos_x = pos;
  assign lo_x  = lo;
  assign hi_x  = hi;
  assign tgt   = step_up ? pos_x + (POS_W+1)'(1) : pos_x - (POS_W+1)'(1);
  assign in_rng   = (tgt >= lo_x) && (tgt <= hi_x);
  assign sw_up    = (pos >= hi) ? 1'b0 : (pos <= lo) ? 1'b1 : dir_q;
  assign idle_cmd = (st == S_IDLE) && !sweep_on && step_req;

  assign ps_en    = (st == S_PULSE);
  assign busy     = (st != S_IDLE);
  assign at_bound = (pos == hi) || (pos == lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      pos       <= '0;
      ps_incdec <= 1'b0;
      dir_q     <= 1'b1;
      wd        <= '0;
      range_err <= 1'b0;
      tmo_err   <= 1'b0;
    end else begin
      range_err <= idle_cmd && !in_rng;
      tmo_err   <= 1'b0;
      case (st)
        S_IDLE: begin
          if (sweep_on) begin
            ps_incdec <= sw_up;
            dir_q     <= sw_up;
            st        <= S_SETUP;
          end else if (idle_cmd && in_rng) begin
            ps_incdec <= step_up;
            st        <= S_SETUP;
          end
        end
        S_SETUP: st <= S_PULSE;
        S_PULSE: begin
          st <= S_WAIT;
          wd <= '0;
        end
        S_WAIT: begin
          if (ps_done) begin
            pos <= ps_incdec ? pos + POS_W'(1) : pos - POS_W'(1);
            st  <= S_IDLE;
          end else if (wd == WD_W'(TIMEOUT - 1)) begin
            tmo_err <= 1'b1;
            st      <= S_IDLE;
          end else begin
            wd <= wd + WD_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_en_single_r2: assert property (@(posedge clk) disable iff (rst)
    ps_en |=> !ps_en);

  p_incdec_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(rst)) |-> $stable(ps_incdec));

  p_pos_gated_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ps_done)) |-> $stable(pos));

  p_step_unit_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && pos != $past(pos)) |->
      (pos == $past(pos) + POS_W'(1) || pos == $past(pos) - POS_W'(1)));

  p_bounds_r5: assert property (@(posedge clk) disable iff (rst)
    (pos <= POS_W'(LIMIT)) && (pos >= -POS_W'(LIMIT)));

  p_tmo_idle_r7: assert property (@(posedge clk) disable iff (rst)
    tmo_err |-> !busy);

  p_err_no_req_r5: assert property (@(posedge clk) disable iff (rst)
    range_err |-> !busy);
endmodule

// File: tb/phase_step_seq_tb.sv
`timescale 1ns/1ps
module phase_step_seq_tb_top;
  localparam int LIM = 255;
  localparam int TMO = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_req = 1'b0, step_up = 1'b0, sweep_on = 1'b0, centered = 1'b1, ps_done = 1'b0;
  logic ps_en, ps_incdec, busy, at_bound, range_err, tmo_err;
  logic signed [9:0] pos;

  always #4 clk = ~clk;

  phase_step_seq #(.POS_W(10), .LIMIT(LIM), .TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst(rst), .step_req(step_req), .step_up(step_up),
    .sweep_on(sweep_on), .centered(centered), .ps_done(ps_done),
    .ps_en(ps_en), .ps_incdec(ps_incdec), .busy(busy), .pos(pos),
    .at_bound(at_bound), .range_err(range_err), .tmo_err(tmo_err));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 prepare, 2 strobe, 3 waiting
  int ph = 0, mpos = 0, mdir = 0, mlast = 1, mwait = 0;
  bit mre = 0, mte = 0;
  always @(posedge clk) begin
    int lo, tg;
    bit ok;
    lo = centered ? -LIM : 0;
    if (rst) begin
      ph = 0; mpos = 0; mdir = 0; mlast = 1; mwait = 0; mre = 0; mte = 0;
    end else begin
      tg = mpos + (step_up ? 1 : -1);
      ok = (tg >= lo) && (tg <= LIM);
      mre = (ph == 0) && !sweep_on && step_req && !ok;
      mte = 0;
      if (ph == 0) begin
        if (sweep_on) begin
          if (mpos >= LIM) mlast = 0;
          else if (mpos <= lo) mlast = 1;
          mdir = mlast; ph = 1;
        end else if (step_req && ok) begin
          mdir = step_up; ph = 1;
        end
      end else if (ph == 1) ph = 2;
      else if (ph == 2) begin ph = 3; mwait = 0; end
      else begin
        mwait++;
        if (ps_done) begin mpos += mdir ? 1 : -1; ph = 0; end
        else if (mwait == TMO) begin mte = 1; ph = 0; end
      end
    end
  end

  bit saw_rerr = 0, saw_tmo = 0, saw_top = 0;
  always @(negedge clk) begin
    int lo;
    if (!finished) begin
      lo = centered ? -LIM : 0;
      chk(ps_en == (ph == 2), "R2 ps_en", ps_en, ph == 2);
      chk(busy == (ph != 0), "R3 busy", busy, ph != 0);
      if (ph != 0) chk(ps_incdec == mdir[0], "R2 incdec", ps_incdec, mdir);
      chk(int'(pos) == mpos, "R4 pos", pos, mpos);
      chk(at_bound == (mpos == LIM || mpos == lo), "R8 at_bound", at_bound, mpos == LIM || mpos == lo);
      chk(range_err == mre, "R5 range_err", range_err, mre);
      chk(tmo_err == mte, "R7 tmo_err", tmo_err, mte);
      if (range_err) saw_rerr = 1;
      if (tmo_err) saw_tmo = 1;
      if (int'(pos) == LIM) saw_top = 1;
    end
  end

  // completion responder with varying delay
  int resp_cnt = 0, seed = 7, fixed_dly = 0;
  bit mute = 0;
  always @(negedge clk) begin
    if (ps_done) ps_done = 1'b0;
    if (resp_cnt > 0) begin
      resp_cnt--;
      if (resp_cnt == 0 && !mute) ps_done = 1'b1;
    end
    if (ps_en && resp_cnt <= 0) begin
      seed = (seed * 1103 + 12345) % 65521;
      resp_cnt = (fixed_dly > 0) ? fixed_dly : 1 + (seed % 13);
    end
  end

  task automatic step(input bit up);
    step_req = 1'b1; step_up = up;
    @(negedge clk);
    step_req = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(pos == 0 && !busy && !ps_en && !range_err && !tmo_err, "R1 reset state", pos, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !ps_en, "R1 idle after reset", busy, 0);

    step(1); step(1); step(1); step(0);
    chk(pos == 2, "R4 single steps", pos, 2);

    centered = 1'b0;
    step(0); step(0);
    saw_rerr = 0;
    step(0);
    chk(saw_rerr, "R5 reject below zero", saw_rerr, 1);
    chk(pos == 0, "R5 pos kept", pos, 0);

    fixed_dly = 30;
    step_req = 1'b1; step_up = 1'b1;
    @(negedge clk); step_req = 1'b0;
    repeat (5) @(negedge clk);
    step_req = 1'b1; step_up = 1'b1;
    @(negedge clk); step_req = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(pos == 1, "R9 command while busy ignored", pos, 1);
    fixed_dly = 0;

    mute = 1'b1; saw_tmo = 0;
    step(1);
    repeat (20) @(negedge clk);
    chk(saw_tmo, "R7 timeout reported", saw_tmo, 1);
    chk(pos == 1, "R7 pos kept", pos, 1);
    mute = 1'b0; resp_cnt = 0;

    saw_top = 0;
    sweep_on = 1'b1;
    step_req = 1'b1; step_up = 1'b0;
    for (int i = 0; i < 20000 && !(saw_top && pos == 0); i++) @(negedge clk);
    step_req = 1'b0;
    sweep_on = 1'b0;
    while (busy) @(negedge clk);
    chk(saw_top, "R6 sweep reached upper bound", saw_top, 1);
    chk(pos <= 1, "R6 sweep returned", pos, 0);

    centered = 1'b1;
    sweep_on = 1'b1;
    repeat (6000) @(negedge clk);
    sweep_on = 1'b0;
    while (busy) @(negedge clk);

    fixed_dly = 40;
    step_req = 1'b1; step_up = 1'b1;
    @(negedge clk); step_req = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pos == 0 && !busy, "R10 reset mid-step", pos, 0);
    repeat (50) @(negedge clk);
    chk(pos == 0 && !busy, "R3 stray done ignored", pos, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule